// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands. Each operand has a sign bit (bit 31), an 8-bit biased exponent (bits 30:23) and a 23-bit fraction (bits 22:0). The operation and one of four rounding directions are chosen per operation at run time. The block aligns the operand with the smaller exponent to the larger one and combines the significands. It then renormalizes the sum and rounds it. The packed result and four exception flags appear one clock after the inputs.

Special operands are resolved ahead of the arithmetic path: NaN inputs, infinities, signed zeros and subnormal values. Results that fall below the normal range leave the block as subnormals, and a zero result always takes a canonical encoding. A control module classifies the operands and hands a small set of strobes to the datapath. The datapath holds the alignment, addition, normalization, rounding and output registers.

Top module: `fp_addsub`

## Requirements
- R1: Operation code 3'b001 computes A minus B. Every other code computes A plus B. The result and flags are registered and show the outcome of the inputs present at the previous rising clock edge.
- R2: Rounding mode 2'b00 rounds to the nearest representable value. An exact tie goes to the value whose least significant fraction bit is 0.
- R3: Rounding mode 2'b01 truncates toward zero. Mode 2'b10 rounds toward +infinity. Mode 2'b11 rounds toward -infinity.
- R4: The inexact flag (flag vector bit 0) is 1 exactly when the delivered finite result differs from the infinitely precise sum. Guard, round and sticky bits carry the bits shifted out during alignment.
- R5: When the rounded exponent reaches 255, the overflow flag (bit 2) and the inexact flag are both set. The result is signed infinity when the rounding direction points away from zero: mode 00 always, mode 10 for a positive result, mode 11 for a negative result. In every other case the result is the largest finite value of that sign (0x7F7FFFFF magnitude).
- R6: An exact zero sum is encoded with exponent and fraction all zero. Operands of like sign give the common sign. Cancelling magnitudes give +0, except under mode 11, which gives -0.
- R7: Any NaN operand (exponent 255, nonzero fraction) yields 0x7FC00000 with the invalid flag (bit 3) set and all other flags clear.
- R8: Infinities of opposite effective sign yield 0x7FC00000 with invalid set. Any other sum involving an infinity returns that infinity with no flags.
- R9: Subnormal operands take part with exponent 1 and no hidden bit. A nonzero result below the normal range is delivered subnormal (exponent field 0), and the underflow flag (bit 1) is set for it.
- R10: While reset is asserted the result and all flags read 0.
- R11: A significand carry-out shifts the sum right and raises the exponent by one. Leading zeros after cancellation shift it left and lower the exponent, but never below the subnormal boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | 3'b001 subtract, otherwise add |
| rndMode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result | output | 32 | Registered sum or difference |
| invalidFlag | output | 1 | NaN produced from an invalid case |
| overflowFlag | output | 1 | Rounded exponent out of range |
| underflowFlag | output | 1 | Nonzero subnormal result |
| inexactFlag | output | 1 | Rounding discarded nonzero bits |

## Verification
The hardest cases to reach are those that depend on the sticky bit surviving both a wide alignment and a one-place left renormalization. Subtracting a value 30 binades smaller from 1.0 is one such case. The truncated result drops to the next value below 1.0. A nearest-even rounding instead carries all the way back up to 1.0. The stimulus table aims operands at exact ties with both even and odd last bits, at this cancellation-plus-sticky path, and at the largest finite value under all four rounding modes, so that each rounding decision is exercised at its boundary.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_e;

  // strobes handed from operand classification to the arithmetic path
  typedef struct packed {
    logic forceNan;
    logic forceInf;
    logic infSign;
    logic subEff;
    logic bSign;
  } ctrl_t;

endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [2:0]            opCode,
  output ctrl_t                 ctrl
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic aMaxExp, bMaxExp, aNan, bNan, aInf, bInf, bSignEff;

  always_comb begin
    aMaxExp  = &opA[W-2:FRAC_W];
    bMaxExp  = &opB[W-2:FRAC_W];
    aNan     = aMaxExp && (|opA[FRAC_W-1:0]);
    bNan     = bMaxExp && (|opB[FRAC_W-1:0]);
    aInf     = aMaxExp && !(|opA[FRAC_W-1:0]);
    bInf     = bMaxExp && !(|opB[FRAC_W-1:0]);
    bSignEff = opB[W-1] ^ (opCode == 3'b001);

    ctrl.bSign    = bSignEff;
    ctrl.subEff   = opA[W-1] ^ bSignEff;
    ctrl.forceNan = aNan || bNan || (aInf && bInf && (opA[W-1] ^ bSignEff));
    ctrl.forceInf = !ctrl.forceNan && (aInf || bInf);
    ctrl.infSign  = aInf ? opA[W-1] : bSignEff;
  end

endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [1:0]            rndMode,
  input  ctrl_t                 ctrl,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalidFlag,
  output logic                  overflowFlag,
  output logic                  underflowFlag,
  output logic                  inexactFlag
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXT_W  = SIG_W + 3;
  localparam int WIDE_W = 2 * SIG_W + 2;
  localparam int EW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0] CLAMP   = EXP_W'(SIG_W + 2);
  localparam logic [EW-1:0]    EXP_TOP = EW'((1 << EXP_W) - 1);
  localparam logic [W-1:0]     QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [LZ_W-1:0] leadZeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] cnt;
    cnt = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) cnt = LZ_W'(EXT_W - 1 - i);
    return cnt;
  endfunction

  logic [W-2:0]        magA, magB, bigMag, smallMag;
  logic                aBig, bigSign, zeroSign, toInf;
  logic [EXP_W-1:0]    eBig, eSmall, diff, shAmt;
  logic [SIG_W-1:0]    sigBig, sigSmall;
  logic [WIDE_W-1:0]   wide;
  logic [EXT_W-1:0]    bigExt, smallExt, norm;
  logic [EXT_W:0]      sum;
  logic [EW-1:0]       eNorm, eOut, room, shl, lzW;
  logic [SIG_W:0]      sigR;
  logic [FRAC_W-1:0]   fracOut;
  logic                roundUp, lostBits, sumZero, ovfNext;
  logic [W-1:0]        resNext;
  logic [3:0]          flagsNext;

  always_comb begin
    // order operands by magnitude so the smaller one is the one shifted
    magA     = opA[W-2:0];
    magB     = opB[W-2:0];
    aBig     = magA >= magB;
    bigMag   = aBig ? magA : magB;
    smallMag = aBig ? magB : magA;
    bigSign  = aBig ? opA[W-1] : ctrl.bSign;

    eBig     = (bigMag[W-2:FRAC_W] == '0) ? EXP_W'(1) : bigMag[W-2:FRAC_W];
    eSmall   = (smallMag[W-2:FRAC_W] == '0) ? EXP_W'(1) : smallMag[W-2:FRAC_W];
    sigBig   = {bigMag[W-2:FRAC_W] != '0, bigMag[FRAC_W-1:0]};
    sigSmall = {smallMag[W-2:FRAC_W] != '0, smallMag[FRAC_W-1:0]};

    // alignment with guard, round and sticky
    diff     = eBig - eSmall;
    shAmt    = (diff > CLAMP) ? CLAMP : diff;
    wide     = {sigSmall, {(SIG_W+2){1'b0}}} >> shAmt;
    smallExt = {wide[WIDE_W-1:SIG_W], |wide[SIG_W-1:0]};
    bigExt   = {sigBig, 3'b000};

    sum      = ctrl.subEff ? ({1'b0, bigExt} - {1'b0, smallExt})
                           : ({1'b0, bigExt} + {1'b0, smallExt});
    sumZero  = (sum == '0);

    // normalization
    lzW  = EW'(leadZeros(sum[EXT_W-1:0]));
    room = EW'(eBig) - EW'(1);
    shl  = (lzW < room) ? lzW : room;
    if (sum[EXT_W]) begin
      norm  = {sum[EXT_W:2], sum[1] | sum[0]};
      eNorm = EW'(eBig) + EW'(1);
    end else begin
      norm  = sum[EXT_W-1:0] << shl;
      eNorm = EW'(eBig) - shl;
    end

    // rounding
    lostBits = |norm[2:0];
    unique case (rnd_e'(rndMode))
      RND_NEAREST: roundUp = norm[2] && (norm[1] || norm[0] || norm[3]);
      RND_ZERO:    roundUp = 1'b0;
      RND_UP:      roundUp = lostBits && !bigSign;
      default:     roundUp = lostBits && bigSign;
    endcase
    sigR = {1'b0, norm[EXT_W-1:3]} + (SIG_W+1)'(roundUp);
    if (sigR[SIG_W]) begin
      eOut    = eNorm + EW'(1);
      fracOut = sigR[SIG_W-1:1];
    end else begin
      eOut    = sigR[SIG_W-1] ? eNorm : '0;
      fracOut = sigR[FRAC_W-1:0];
    end

    ovfNext  = !ctrl.forceNan && !ctrl.forceInf && !sumZero && (eOut >= EXP_TOP);
    zeroSign = ctrl.subEff ? (rnd_e'(rndMode) == RND_DOWN) : bigSign;
    toInf    = (rnd_e'(rndMode) == RND_NEAREST) ||
               ((rnd_e'(rndMode) == RND_UP) && !bigSign) ||
               ((rnd_e'(rndMode) == RND_DOWN) && bigSign);

    // flag vector {invalid, overflow, underflow, inexact}
    if (ctrl.forceNan) begin
      resNext   = QNAN;
      flagsNext = 4'b1000;
    end else if (ctrl.forceInf) begin
      resNext   = {ctrl.infSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flagsNext = 4'b0000;
    end else if (sumZero) begin
      resNext   = {zeroSign, {(W-1){1'b0}}};
      flagsNext = 4'b0000;
    end else if (ovfNext) begin
      resNext   = toInf ? {bigSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                        : {bigSign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      flagsNext = 4'b0101;
    end else begin
      resNext   = {bigSign, eOut[EXP_W-1:0], fracOut};
      flagsNext = {2'b00, eOut == '0, lostBits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result        <= '0;
      invalidFlag   <= 1'b0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      inexactFlag   <= 1'b0;
    end else begin
      result        <= resNext;
      invalidFlag   <= flagsNext[3];
      overflowFlag  <= flagsNext[2];
      underflowFlag <= flagsNext[1];
      inexactFlag   <= flagsNext[0];
    end
  end

  // R7
  invalid_qnan_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> (result == QNAN && !overflowFlag && !inexactFlag && !underflowFlag));

  // R5
  overflow_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> inexactFlag);

  // R5
  overflow_nearest_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfNext && rndMode == 2'b00) |=> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R9
  underflow_subnormal_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |-> (result[W-2:FRAC_W] == '0 && result[FRAC_W-1:0] != '0));

  // R8
  infinity_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.forceInf |=> (!invalidFlag && !overflowFlag && !inexactFlag && result[W-2:FRAC_W] == '1));

endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [2:0]            opCode,
  input  logic [1:0]            rndMode,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalidFlag,
  output logic                  overflowFlag,
  output logic                  underflowFlag,
  output logic                  inexactFlag
);
  ctrl_t ctrl;

  fpadd_ctrl #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_ctrl (
    .opA(opA), .opB(opB), .opCode(opCode), .ctrl(ctrl)
  );

  fpadd_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .rndMode(rndMode),
    .ctrl(ctrl), .result(result), .invalidFlag(invalidFlag),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag),
    .inexactFlag(inexactFlag)
  );

endmodule

// File: tb/test_fp_addsub.sv
`timescale 1ns/1ps
module test_fp_addsub;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  opCode = '0;
  logic [1:0]  rndMode = '0;
  logic [31:0] result;
  logic        invalidFlag, overflowFlag, underflowFlag, inexactFlag;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_addsub i_fp_addsub (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .rndMode(rndMode), .result(result), .invalidFlag(invalidFlag),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag),
    .inexactFlag(inexactFlag)
  );

  // {A, B, opCode, rndMode, expected result, flags {inv,ovf,unf,inx}, requirement number}
  localparam int NV = 27;
  localparam logic [108:0] VECS [NV] = '{
    {32'h43750000, 32'h42200000, 3'd0, 2'd0, 32'h438E8000, 4'b0000, 4'd1},  // R1 245+40
    {32'h43750000, 32'h42200000, 3'd1, 2'd0, 32'h434D0000, 4'b0000, 4'd1},  // R1 245-40
    {32'h43750000, 32'h42200000, 3'd2, 2'd0, 32'h438E8000, 4'b0000, 4'd1},  // R1 other code adds
    {32'h3F800000, 32'h80000000, 3'd0, 2'd0, 32'h3F800000, 4'b0000, 4'd1},  // R1 1 + -0
    {32'h3F800000, 32'h3F800000, 3'd0, 2'd0, 32'h40000000, 4'b0000, 4'd11}, // R11 carry out
    {32'h3FC00000, 32'h3F800000, 3'd1, 2'd0, 32'h3F000000, 4'b0000, 4'd11}, // R11 cancellation
    {32'h3F800000, 32'h33800000, 3'd0, 2'd0, 32'h3F800000, 4'b0001, 4'd2},  // R2 tie to even (down)
    {32'h3F800001, 32'h33800000, 3'd0, 2'd0, 32'h3F800002, 4'b0001, 4'd2},  // R2 tie to even (up)
    {32'h3F800000, 32'h33800000, 3'd0, 2'd2, 32'h3F800001, 4'b0001, 4'd3},  // R3 toward +inf
    {32'h3F800000, 32'h30800000, 3'd1, 2'd1, 32'h3F7FFFFF, 4'b0001, 4'd3},  // R3 toward zero
    {32'h3F800000, 32'h30800000, 3'd1, 2'd3, 32'h3F7FFFFF, 4'b0001, 4'd3},  // R3 toward -inf
    {32'h3F800000, 32'h30800000, 3'd1, 2'd0, 32'h3F800000, 4'b0001, 4'd4},  // R4 sticky through shift
    {32'h3F800000, 32'h3F800000, 3'd1, 2'd0, 32'h00000000, 4'b0000, 4'd6},  // R6 +0
    {32'h3F800000, 32'h3F800000, 3'd1, 2'd3, 32'h80000000, 4'b0000, 4'd6},  // R6 -0 under mode 11
    {32'h80000000, 32'h80000000, 3'd0, 2'd0, 32'h80000000, 4'b0000, 4'd6},  // R6 -0 + -0
    {32'h7F800001, 32'h3F800000, 3'd0, 2'd0, 32'h7FC00000, 4'b1000, 4'd7},  // R7 signalling NaN in A
    {32'h3F800000, 32'hFFC00000, 3'd1, 2'd0, 32'h7FC00000, 4'b1000, 4'd7},  // R7 NaN in B
    {32'h7F800000, 32'h7F800000, 3'd1, 2'd0, 32'h7FC00000, 4'b1000, 4'd8},  // R8 inf - inf
    {32'hFF800000, 32'h3F800000, 3'd0, 2'd0, 32'hFF800000, 4'b0000, 4'd8},  // R8 -inf + 1
    {32'h7F800000, 32'h3F800000, 3'd1, 2'd0, 32'h7F800000, 4'b0000, 4'd8},  // R8 inf - 1
    {32'h7F7FFFFF, 32'h7F7FFFFF, 3'd0, 2'd0, 32'h7F800000, 4'b0101, 4'd5},  // R5 nearest -> inf
    {32'h7F7FFFFF, 32'h7F7FFFFF, 3'd0, 2'd1, 32'h7F7FFFFF, 4'b0101, 4'd5},  // R5 zero -> max
    {32'hFF7FFFFF, 32'hFF7FFFFF, 3'd0, 2'd2, 32'hFF7FFFFF, 4'b0101, 4'd5},  // R5 up, negative -> -max
    {32'hFF7FFFFF, 32'h7F7FFFFF, 3'd1, 2'd3, 32'hFF800000, 4'b0101, 4'd5},  // R5 down, negative -> -inf
    {32'h00000001, 32'h00000001, 3'd0, 2'd0, 32'h00000002, 4'b0010, 4'd9},  // R9 subnormal sum
    {32'h00800000, 32'h00000001, 3'd1, 2'd0, 32'h007FFFFF, 4'b0010, 4'd9},  // R9 falls below normal
    {32'h007FFFFF, 32'h00000001, 3'd0, 2'd0, 32'h00800000, 4'b0000, 4'd9}   // R9 rises to normal
  };

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flagsNow();
    return {invalidFlag, overflowFlag, underflowFlag, inexactFlag};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    checkVal("R10 result in reset", result, 32'h0);
    checkVal("R10 flags in reset", {28'h0, flagsNow()}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opA = VECS[i][108:77]; opB = VECS[i][76:45];
      opCode = VECS[i][44:42]; rndMode = VECS[i][41:40];
      @(negedge clk);
      checks++;
      if (result !== VECS[i][39:8] || flagsNow() !== VECS[i][7:4]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%08h/%04b expected=%08h/%04b",
                 VECS[i][3:0], i, result, flagsNow(), VECS[i][39:8], VECS[i][7:4]);
      end
    end

    // R1 latency: new inputs leave the output unchanged until the next edge
    @(negedge clk);
    opA = 32'h3F800000; opB = 32'h3F800000; opCode = 3'd0; rndMode = 2'd0;
    @(negedge clk);
    checkVal("R1 settled", result, 32'h40000000);
    @(posedge clk);
    #1 opCode = 3'd1;
    #1.5 checkVal("R1 held until edge", result, 32'h40000000);
    @(negedge clk);
    checkVal("R1 after edge", result, 32'h00000000);

    // R10 reset mid-run clears an overflow outcome
    opA = 32'h7F7FFFFF; opB = 32'h7F7FFFFF; opCode = 3'd0; rndMode = 2'd0;
    @(negedge clk);
    checkVal("R5 before reset", {28'h0, flagsNow()}, 32'h5);
    rstN = 1'b0;
    #1;
    checkVal("R10 result after reset", result, 32'h0);
    checkVal("R10 flags after reset", {28'h0, flagsNow()}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule